// File: doc/BRIEF.md
# Embedding Gather, Pool and Update Engine

This block keeps one embedding table of `ROWS` rows, each row holding `DIM` signed Q8.8 elements, in local flop storage. In the forward direction a stream of row indices arrives with markers for the first and last index of a bag. Each named row is read and added element by element into a running sum, and the pooled vector leaves one cycle after the last index of the bag. Every looked-up row is also kept, together with its index, in a private bag buffer.

In the backward direction one pooled gradient vector is applied to the most recently finished bag. The gradient is scaled by an arithmetic right shift that combines a learning-rate shift and a batch-size shift, which averages it over the batch. It is then subtracted from the buffered copy of every contributing row, and the result is written back to the table one row per cycle. Because the old row values are already in the buffer, the write-back never reads the table.

A row named twice in a bag is stepped once per occurrence, and the occurrences are applied in arrival order. A separate load port fills the table before use.

Top module: `emb_pool_engine`

## Requirements
- R1: After reset `pool_valid_o` and `busy_o` are low and every table element reads back as zero.
- R2: A load (`ld_valid_i` high while `busy_o` is low) replaces the whole row `ld_row_i` with `ld_data_i`. A later single-index bag on that row returns exactly that data.
- R3: For a bag, `pool_valid_o` is high for one cycle, starting the cycle after the index carrying `idx_last_i` is accepted. `pool_data_o` then holds the element-wise sum of the bag's rows and stays unchanged until the next pooled result. Element i occupies bits [16i+15:16i] as signed two's complement.
- R4: Each addition saturates, in arrival order, at 32767 (0x7FFF) and -32768 (0x8000).
- R5: An index of `ROWS` or more adds zero to the sum and sets `pool_err_o` for that bag's result. A bag whose indices are all valid reports `pool_err_o` low.
- R6: An accepted gradient writes every buffered in-range row as old - (g >>> (`lr_shift_i` + `batch_log2_i`)), element by element. Here old is the value read in the forward pass, and the shift is arithmetic.
- R7: A row that appears n times in the bag receives n steps, applied in arrival order.
- R8: After a gradient is accepted, `busy_o` stays high for exactly as many cycles as there are buffered bag entries. Out-of-range entries take a cycle each but write nothing.
- R9: While `busy_o` is high, loads, indices and gradients are ignored. A gradient presented together with `idx_valid_i` is also ignored.
- R10: The subtraction in the update saturates at 32767 and -32768.
- R11: Only the first `MAX_BAG` entries of a longer bag are buffered and updated, but all of its entries are pooled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Table row load strobe |
| ld_row_i | input | IDX_W | Row being loaded |
| ld_data_i | input | DIM*16 | Row contents to load |
| idx_valid_i | input | 1 | Index strobe |
| idx_first_i | input | 1 | Index opens a new bag |
| idx_last_i | input | 1 | Index closes the bag |
| idx_i | input | IDX_W | Row index |
| pool_valid_o | output | 1 | Pooled vector strobe |
| pool_data_o | output | DIM*16 | Pooled vector |
| pool_err_o | output | 1 | Bag contained an out-of-range index |
| grad_valid_i | input | 1 | Gradient strobe |
| grad_i | input | DIM*16 | Pooled gradient vector |
| lr_shift_i | input | 4 | Learning-rate right shift |
| batch_log2_i | input | 4 | Batch-average right shift |
| busy_o | output | 1 | Write-back in progress |

## Verification
Most wrong internal states here stay hidden until a row is read again. A stale or unpatched buffer entry, a wrong step, or a write to the wrong row shows up only in the pooled result of a later single-index bag on the affected rows. That result appears one cycle after the lookup, so the bench reads back every touched row and every row that should have stayed untouched after each update. Errors in the bag pointer or count show at once as a wrong `busy_o` length. Accumulator faults show in the very next `pool_data_o`, and the saturation corners are placed so that saturating each addition and saturating only the final sum give different answers.

// File: rtl/emb_pkg.sv
package emb_pkg;
  localparam int ELEM_W = 16;
  typedef logic signed [ELEM_W-1:0] elem_t;
  localparam elem_t ELEM_MAX = 16'sh7fff;
  localparam elem_t ELEM_MIN = 16'sh8000;

  function automatic elem_t sat_add(elem_t a, elem_t b);
    logic signed [ELEM_W:0] s;
    s = {a[ELEM_W-1], a} + {b[ELEM_W-1], b};
    if (s[ELEM_W] != s[ELEM_W-1]) return s[ELEM_W] ? ELEM_MIN : ELEM_MAX;
    return s[ELEM_W-1:0];
  endfunction

  function automatic elem_t sat_sub(elem_t a, elem_t b);
    logic signed [ELEM_W:0] s;
    s = {a[ELEM_W-1], a} - {b[ELEM_W-1], b};
    if (s[ELEM_W] != s[ELEM_W-1]) return s[ELEM_W] ? ELEM_MIN : ELEM_MAX;
    return s[ELEM_W-1:0];
  endfunction

  function automatic elem_t ashr(elem_t a, logic [4:0] sh);
    return a >>> sh;
  endfunction
endpackage

// File: rtl/emb_table.sv
module emb_table import emb_pkg::*; #(
  parameter int ROWS  = 12,
  parameter int DIM   = 4,
  parameter int IDX_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output elem_t [DIM-1:0]       rd_row_o,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  elem_t [DIM-1:0]       wr_row_i
);
  elem_t [DIM-1:0] mem_q [ROWS];
  logic rd_in, wr_in;

  assign rd_in = {1'b0, rd_idx_i} < (IDX_W+1)'(ROWS);
  assign wr_in = {1'b0, wr_idx_i} < (IDX_W+1)'(ROWS);

  always_comb begin
    rd_row_o = '0;
    if (rd_in) rd_row_o = mem_q[rd_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (wr_en_i && wr_in) begin
      mem_q[wr_idx_i] <= wr_row_i;
    end
  end
endmodule

// File: rtl/emb_pool_acc.sv
module emb_pool_acc import emb_pkg::*; #(
  parameter int DIM = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            in_first_i,
  input  logic            in_last_i,
  input  logic            in_ok_i,
  input  elem_t [DIM-1:0] in_row_i,
  output logic            out_valid_o,
  output elem_t [DIM-1:0] out_vec_o,
  output logic            out_err_o
);
  elem_t [DIM-1:0] acc_q, acc_n;
  logic err_q, err_n;

  always_comb begin
    for (int i = 0; i < DIM; i++)
      acc_n[i] = sat_add(in_first_i ? elem_t'(0) : acc_q[i],
                         in_ok_i ? in_row_i[i] : elem_t'(0));
    err_n = (in_first_i ? 1'b0 : err_q) | ~in_ok_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      err_q       <= 1'b0;
      out_valid_o <= 1'b0;
      out_vec_o   <= '0;
      out_err_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i & in_last_i;
      if (in_valid_i) begin
        acc_q <= acc_n;
        err_q <= err_n;
        if (in_last_i) begin
          out_vec_o <= acc_n;
          out_err_o <= err_n;
        end
      end
    end
  end
endmodule

// File: rtl/emb_upd_seq.sv
module emb_upd_seq import emb_pkg::*; #(
  parameter int DIM     = 4,
  parameter int MAX_BAG = 6,
  parameter int IDX_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_valid_i,
  input  logic             cap_first_i,
  input  logic             cap_ok_i,
  input  logic [IDX_W-1:0] cap_idx_i,
  input  elem_t [DIM-1:0]  cap_row_i,
  input  logic             grad_valid_i,
  input  elem_t [DIM-1:0]  grad_i,
  input  logic [4:0]       shift_i,
  output logic             busy_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output elem_t [DIM-1:0]  wr_row_o
);
  localparam int CNT_W = $clog2(MAX_BAG + 1);

  logic [IDX_W-1:0] buf_idx [MAX_BAG];
  logic             buf_ok  [MAX_BAG];
  elem_t [DIM-1:0]  buf_row [MAX_BAG];
  elem_t [DIM-1:0]  step_q;
  logic [CNT_W-1:0] cnt_q, ptr_q, slot, last_ptr;
  logic             busy_q, slot_ok;

  assign slot     = cap_first_i ? '0 : cnt_q;
  assign slot_ok  = slot < CNT_W'(MAX_BAG);
  assign last_ptr = cnt_q - 1'b1;
  assign busy_o   = busy_q;
  assign wr_en_o  = busy_q & buf_ok[ptr_q];
  assign wr_idx_o = buf_idx[ptr_q];

  always_comb
    for (int i = 0; i < DIM; i++) wr_row_o[i] = sat_sub(buf_row[ptr_q][i], step_q[i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < MAX_BAG; j++) begin
        buf_idx[j] <= '0;
        buf_ok[j]  <= 1'b0;
        buf_row[j] <= '0;
      end
      step_q <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      // later copies of the same row inherit the freshly stepped value
      for (int j = 0; j < MAX_BAG; j++)
        if (wr_en_o && CNT_W'(j) > ptr_q && buf_idx[j] == wr_idx_o) buf_row[j] <= wr_row_o;
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == last_ptr) busy_q <= 1'b0;
    end else if (cap_valid_i) begin
      if (slot_ok) begin
        buf_idx[slot] <= cap_idx_i;
        buf_ok[slot]  <= cap_ok_i;
        buf_row[slot] <= cap_row_i;
        cnt_q         <= slot + 1'b1;
      end
    end else if (grad_valid_i) begin
      for (int i = 0; i < DIM; i++) step_q[i] <= ashr(grad_i[i], shift_i);
      ptr_q  <= '0;
      busy_q <= (cnt_q != '0);
    end
  end
endmodule

// File: rtl/emb_pool_engine.sv
module emb_pool_engine import emb_pkg::*; #(
  parameter int ROWS    = 12,
  parameter int DIM     = 4,
  parameter int MAX_BAG = 6,
  parameter int IDX_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_valid_i,
  input  logic [IDX_W-1:0]        ld_row_i,
  input  logic [DIM*ELEM_W-1:0]   ld_data_i,
  input  logic                    idx_valid_i,
  input  logic                    idx_first_i,
  input  logic                    idx_last_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic                    pool_valid_o,
  output logic [DIM*ELEM_W-1:0]   pool_data_o,
  output logic                    pool_err_o,
  input  logic                    grad_valid_i,
  input  logic [DIM*ELEM_W-1:0]   grad_i,
  input  logic [3:0]              lr_shift_i,
  input  logic [3:0]              batch_log2_i,
  output logic                    busy_o
);
  logic             busy, idx_go, grad_go, idx_ok, upd_wr, wr_en;
  logic [IDX_W-1:0] upd_idx, wr_idx;
  logic [4:0]       shift_amt;
  elem_t [DIM-1:0]  rd_row, ld_vec, grad_vec, upd_row, wr_row, pool_vec;

  assign ld_vec    = ld_data_i;
  assign grad_vec  = grad_i;
  assign shift_amt = {1'b0, lr_shift_i} + {1'b0, batch_log2_i};
  assign idx_go    = idx_valid_i & ~busy;
  assign grad_go   = grad_valid_i & ~busy & ~idx_valid_i;
  assign idx_ok    = {1'b0, idx_i} < (IDX_W+1)'(ROWS);
  assign wr_en     = busy ? upd_wr : ld_valid_i;
  assign wr_idx    = busy ? upd_idx : ld_row_i;
  assign wr_row    = busy ? upd_row : ld_vec;
  assign busy_o    = busy;
  assign pool_data_o = pool_vec;

  emb_table #(.ROWS(ROWS), .DIM(DIM), .IDX_W(IDX_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (idx_i),
    .rd_row_o (rd_row),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_row_i (wr_row)
  );

  emb_pool_acc #(.DIM(DIM)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (idx_go),
    .in_first_i  (idx_first_i),
    .in_last_i   (idx_last_i),
    .in_ok_i     (idx_ok),
    .in_row_i    (rd_row),
    .out_valid_o (pool_valid_o),
    .out_vec_o   (pool_vec),
    .out_err_o   (pool_err_o)
  );

  emb_upd_seq #(.DIM(DIM), .MAX_BAG(MAX_BAG), .IDX_W(IDX_W)) u_upd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_valid_i  (idx_go),
    .cap_first_i  (idx_first_i),
    .cap_ok_i     (idx_ok),
    .cap_idx_i    (idx_i),
    .cap_row_i    (rd_row),
    .grad_valid_i (grad_go),
    .grad_i       (grad_vec),
    .shift_i      (shift_amt),
    .busy_o       (busy),
    .wr_en_o      (upd_wr),
    .wr_idx_o     (upd_idx),
    .wr_row_o     (upd_row)
  );
endmodule

// File: rtl/emb_pool_engine_chk.sv
module emb_pool_engine_chk #(
  parameter int DIM     = 4,
  parameter int MAX_BAG = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              idx_valid_i,
  input logic              idx_last_i,
  input logic              grad_valid_i,
  input logic              pool_valid_o,
  input logic [DIM*16-1:0] pool_data_o,
  input logic              pool_err_o,
  input logic              busy_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (busy_o) run_q <= run_q + 16'd1;
    else run_q <= '0;
  end

  // R3: a result only follows an accepted closing index
  a_r3_pool_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pool_valid_o |-> $past(idx_valid_i && idx_last_i && !busy_o));

  // R3: result held between strobes
  a_r3_pool_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pool_valid_o |-> ($stable(pool_data_o) && $stable(pool_err_o)));

  // R9: no new bag completes during write-back
  a_r9_no_pool_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> !pool_valid_o);

  // R8: write-back never runs longer than the buffer
  a_r8_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(run_q) < MAX_BAG));

  // R6: write-back starts only from a gradient
  a_r6_busy_from_grad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(grad_valid_i));
endmodule

bind emb_pool_engine emb_pool_engine_chk #(.DIM(DIM), .MAX_BAG(MAX_BAG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .idx_valid_i  (idx_valid_i),
  .idx_last_i   (idx_last_i),
  .grad_valid_i (grad_valid_i),
  .pool_valid_o (pool_valid_o),
  .pool_data_o  (pool_data_o),
  .pool_err_o   (pool_err_o),
  .busy_o       (busy_o)
);

// File: tb/emb_pool_engine_tb.sv
module emb_pool_engine_tb;
  localparam int ROWS = 12, DIM = 4, MAX_BAG = 6, IDX_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ld_valid_i = 1'b0, idx_valid_i = 1'b0, idx_first_i = 1'b0, idx_last_i = 1'b0;
  logic grad_valid_i = 1'b0;
  logic [IDX_W-1:0] ld_row_i = '0, idx_i = '0;
  logic [DIM*16-1:0] ld_data_i = '0, grad_i = '0, pool_data_o;
  logic [3:0] lr_shift_i = '0, batch_log2_i = '0;
  logic pool_valid_o, pool_err_o, busy_o;

  always #5 clk = ~clk;

  emb_pool_engine #(.ROWS(ROWS), .DIM(DIM), .MAX_BAG(MAX_BAG), .IDX_W(IDX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ld_valid_i(ld_valid_i), .ld_row_i(ld_row_i), .ld_data_i(ld_data_i),
    .idx_valid_i(idx_valid_i), .idx_first_i(idx_first_i), .idx_last_i(idx_last_i), .idx_i(idx_i),
    .pool_valid_o(pool_valid_o), .pool_data_o(pool_data_o), .pool_err_o(pool_err_o),
    .grad_valid_i(grad_valid_i), .grad_i(grad_i), .lr_shift_i(lr_shift_i),
    .batch_log2_i(batch_log2_i), .busy_o(busy_o)
  );

  int n_chk = 0, n_fail = 0;
  int tbl [ROWS][DIM];
  int bag [16];
  int bag_n;
  int vec [DIM];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int el(input logic [DIM*16-1:0] v, input int i);
    return int'($signed(v[i*16 +: 16]));
  endfunction

  task automatic load_row(input int r);
    @(negedge clk);
    ld_valid_i = 1'b1;
    ld_row_i = r[IDX_W-1:0];
    for (int d = 0; d < DIM; d++) ld_data_i[d*16 +: 16] = vec[d][15:0];
    @(posedge clk); #1;
    ld_valid_i = 1'b0;
    if (r < ROWS) for (int d = 0; d < DIM; d++) tbl[r][d] = vec[d];
  endtask

  task automatic do_bag(input string req);
    int exp [DIM];
    bit eerr;
    eerr = 1'b0;
    for (int d = 0; d < DIM; d++) exp[d] = 0;
    for (int k = 0; k < bag_n; k++) begin
      @(negedge clk);
      idx_valid_i = 1'b1;
      idx_first_i = (k == 0);
      idx_last_i  = (k == bag_n - 1);
      idx_i = bag[k][IDX_W-1:0];
      if (bag[k] < ROWS) for (int d = 0; d < DIM; d++) exp[d] = sat(exp[d] + tbl[bag[k]][d]);
      else eerr = 1'b1;
      @(posedge clk); #1;
      if (k < bag_n - 1) chk(pool_valid_o == 1'b0, req, "early pool_valid", int'(pool_valid_o), 0);
    end
    chk(pool_valid_o == 1'b1, req, "pool_valid", int'(pool_valid_o), 1);
    for (int d = 0; d < DIM; d++) chk(el(pool_data_o, d) == exp[d], req, "pool element", el(pool_data_o, d), exp[d]);
    chk(pool_err_o == eerr, req, "pool_err", int'(pool_err_o), int'(eerr));
    @(negedge clk);
    idx_valid_i = 1'b0; idx_first_i = 1'b0; idx_last_i = 1'b0;
    @(posedge clk); #1;
    chk(pool_valid_o == 1'b0, req, "pulse width", int'(pool_valid_o), 0);
  endtask

  task automatic read_row(input int r, input string req);
    bag[0] = r; bag_n = 1;
    do_bag(req);
  endtask

  // applies vec as gradient to the last bag; optionally pokes a load into row poke_r while busy
  task automatic do_grad(input int lr, input int bl, input bit poke, input int poke_r, input string req);
    int nb, cyc, step;
    nb = (bag_n < MAX_BAG) ? bag_n : MAX_BAG;
    @(negedge clk);
    grad_valid_i = 1'b1;
    for (int d = 0; d < DIM; d++) grad_i[d*16 +: 16] = vec[d][15:0];
    lr_shift_i = lr[3:0]; batch_log2_i = bl[3:0];
    @(posedge clk); #1;
    grad_valid_i = 1'b0;
    cyc = 0;
    while (busy_o && cyc < 100) begin
      if (poke && cyc == 0) begin
        @(negedge clk);
        ld_valid_i = 1'b1; ld_row_i = poke_r[IDX_W-1:0];
        for (int d = 0; d < DIM; d++) ld_data_i[d*16 +: 16] = 16'h1234;
      end
      @(posedge clk); #1;
      ld_valid_i = 1'b0;
      cyc++;
    end
    chk(cyc == nb, "R8", "busy length", cyc, nb);
    for (int k = 0; k < nb; k++)
      if (bag[k] < ROWS)
        for (int d = 0; d < DIM; d++) begin
          step = vec[d] >>> (lr + bl);
          tbl[bag[k]][d] = sat(tbl[bag[k]][d] - step);
        end
  endtask

  task automatic check_all_rows(input string req);
    for (int r = 0; r < ROWS; r++) read_row(r, req);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) for (int d = 0; d < DIM; d++) tbl[r][d] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(pool_valid_o == 1'b0, "R1", "pool_valid in reset", int'(pool_valid_o), 0);
    chk(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    check_all_rows("R1");

    // R2: fill the table and read every row back
    for (int r = 0; r < ROWS; r++) begin
      for (int d = 0; d < DIM; d++) vec[d] = ((r * 37 + d * 53) % 211 - 105) * 8;
      load_row(r);
    end
    check_all_rows("R2");

    // R3: several bag shapes
    bag_n = 3; bag[0] = 0; bag[1] = 1; bag[2] = 2; do_bag("R3");
    bag_n = 4; bag[0] = 5; bag[1] = 5; bag[2] = 7; bag[3] = 11; do_bag("R3");
    bag_n = MAX_BAG; for (int k = 0; k < MAX_BAG; k++) bag[k] = 11 - k; do_bag("R3");
    for (int t = 0; t < 40; t++) begin
      bag_n = $urandom_range(MAX_BAG, 1);
      for (int k = 0; k < bag_n; k++) bag[k] = $urandom_range(15, 0);
      do_bag((bag[0] >= ROWS) ? "R5" : "R3");
    end

    // R4: per-addition saturation
    for (int d = 0; d < DIM; d++) vec[d] = 28672; load_row(0); load_row(1);
    for (int d = 0; d < DIM; d++) vec[d] = -28672; load_row(2); load_row(3);
    bag_n = 2; bag[0] = 0; bag[1] = 1; do_bag("R4");
    bag_n = 2; bag[0] = 2; bag[1] = 3; do_bag("R4");
    bag_n = 3; bag[0] = 0; bag[1] = 1; bag[2] = 2; do_bag("R4");

    // R5: out-of-range indices
    bag_n = 3; bag[0] = 4; bag[1] = 13; bag[2] = 5; do_bag("R5");
    bag_n = 1; bag[0] = 4; do_bag("R5");
    bag_n = 1; bag[0] = 15; do_bag("R5");

    // R6: plain update
    bag_n = 3; bag[0] = 1; bag[1] = 2; bag[2] = 3; do_bag("R6");
    vec[0] = 1000; vec[1] = -1000; vec[2] = 7; vec[3] = -32768;
    do_grad(2, 1, 1'b0, 0, "R6");
    check_all_rows("R6");

    // R7: repeated row
    bag_n = 4; bag[0] = 4; bag[1] = 4; bag[2] = 6; bag[3] = 4; do_bag("R7");
    vec[0] = 256; vec[1] = -512; vec[2] = 3; vec[3] = 100;
    do_grad(1, 0, 1'b0, 0, "R7");
    read_row(4, "R7"); read_row(6, "R7");

    // R8: out-of-range entries take a slot but write nothing
    bag_n = 3; bag[0] = 7; bag[1] = 14; bag[2] = 8; do_bag("R8");
    vec[0] = 64; vec[1] = 64; vec[2] = -64; vec[3] = 1;
    do_grad(0, 2, 1'b0, 0, "R8");
    check_all_rows("R8");

    // R10: subtraction saturates
    for (int d = 0; d < DIM; d++) vec[d] = (d < 2) ? -32000 : 32000; load_row(9);
    bag_n = 1; bag[0] = 9; do_bag("R10");
    vec[0] = 32767; vec[1] = 32767; vec[2] = -32768; vec[3] = -32768;
    do_grad(0, 0, 1'b0, 0, "R10");
    read_row(9, "R10");

    // R9: a load during write-back is ignored
    bag_n = 3; bag[0] = 10; bag[1] = 11; bag[2] = 10; do_bag("R9");
    vec[0] = 40; vec[1] = 80; vec[2] = -40; vec[3] = 0;
    do_grad(1, 1, 1'b1, 0, "R9");
    read_row(0, "R9"); read_row(10, "R9"); read_row(11, "R9");

    // R11: long bag pooled fully, only first MAX_BAG updated
    bag_n = 8; for (int k = 0; k < 8; k++) bag[k] = k; do_bag("R11");
    vec[0] = 512; vec[1] = 512; vec[2] = 512; vec[3] = 512;
    do_grad(3, 0, 1'b0, 0, "R11");
    check_all_rows("R11");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule